// File: doc/BRIEF.md
# Error-Rate Automute Controller

This block decides, sample by sample, whether the audio path carries the decoded digital sound, falls back to the analog FM sound, or goes silent. It counts the error flags raised by the upstream decoder over fixed measurement windows. At the end of each window it latches the total as an error count byte. It then compares that total against two programmable limits. A high limit engages automute and a low limit releases it. Between the two limits the previous decision stands. This hysteresis stops the output from flapping when the error rate hovers around a single threshold.

The automute decision is merged with an active-low external mute pin, a mute-definition control bit, the reserve-sound flag and the digital-validity flag. The merge produces a two-bit source code and a data-zeroing strobe. The window is derived from a sample-rate tick. With the default of 4096 ticks at a 32 kHz sample rate, each window lasts 128 ms.

Top module: `automute_ctrl`

## Requirements
- R1: After reset the latched error count is 0 and the automute flag is 0. With the validity flag at 1 and the mute pin high, the source code is 2'b00 (digital) and the zero strobe is low.
- R2: The latched error count changes only at the end of a window. At all other times it holds its value.
- R3: A window ends on the TICKS_PER_WINDOW-th sample tick counted since the previous window end, or since reset. The new count is visible on the clock edge that takes that tick.
- R4: The per-window error total saturates at its all-ones value (255 for 8 bits). It does not wrap.
- R5: While the automute function is enabled and automute is off, a window total greater than or equal to the upper limit turns automute on.
- R6: While automute is on, a window total less than or equal to the lower limit turns it off. Any total strictly between the limits leaves the state unchanged.
- R7: While the disable input is 1, the automute flag is cleared on the next edge and held at 0 whatever the window totals are. Error counting continues.
- R8: When the validity flag is 0, the source code is 2'b01 (FM) for every combination of the mute pin, the automute state, the mute-definition bit and the reserve-sound flag.
- R9: When the validity flag is 1 and the mute condition holds, the source code is 2'b01 (FM) if both the mute-definition bit and the reserve-sound flag are 1. Otherwise it is 2'b10 (silence).
- R10: An engaged automute asserts the mute condition on its own, exactly as a low mute pin does. With automute on and the validity flag at 1, the source code is never 2'b00.
- R11: The zero strobe is 1 exactly when the source code is not 2'b00. The automute flag output equals the automute state.
- R12: An error flag that arrives on the same cycle as the window-ending tick is counted in the window that is ending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_flag | input | 1 | One-cycle strobe per decoder error |
| sample_tick | input | 1 | One-cycle strobe per audio sample period |
| upper_lim | input | CNT_W | Window total at or above which automute engages |
| lower_lim | input | CNT_W | Window total at or below which automute releases |
| am_disable | input | 1 | 1 switches the automute function off |
| mute_def | input | 1 | 1 lets a mute fall back to FM when the reserve-sound flag allows it |
| rssf | input | 1 | Reserve-sound flag: FM carries the same programme |
| vdsp | input | 1 | 1 when the digital stream is valid sound |
| mute_n | input | 1 | External mute request, active low |
| err_count | output | CNT_W | Error total of the last completed window |
| am_flag | output | 1 | 1 while automute is engaged |
| src_sel | output | 2 | 00 digital, 01 FM, 10 silence |
| zero_data | output | 1 | 1 when the digital samples are to be forced to zero |

## Verification
The assertions assume that the error and sample strobes are synchronous single-bit inputs. They assume that the limits and the disable bit change only between clock edges. They also assume that a window end is the only event that may move the count or the automute state, apart from the disable bit. The stimulus drives every input on the falling clock edge and changes the limits only between windows. It runs the window-size configuration at four ticks, so that sweeps over window totals, limit crossings and all 32 combinations of the output-selection inputs stay short.

// File: rtl/automute_pkg.sv
package automute_pkg;

   typedef enum logic [1:0] {
      SRC_DIGITAL = 2'b00,
      SRC_FM      = 2'b01,
      SRC_SILENT  = 2'b10
   } src_sel_t;

endpackage

// File: rtl/am_window_timer.sv
module am_window_timer #(
   parameter int TICKS_PER_WINDOW = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_tick,
   output logic win_end
);
   localparam int TICKS = (TICKS_PER_WINDOW < 2) ? 2 : TICKS_PER_WINDOW;
   localparam int PW    = $clog2(TICKS);
   localparam logic [PW-1:0] LAST = PW'(TICKS - 1);

   logic [PW-1:0] tick_cnt;

   assign win_end = sample_tick && (tick_cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_cnt <= '0;
      end else if (sample_tick) begin
         if (tick_cnt == LAST) tick_cnt <= '0;
         else                  tick_cnt <= tick_cnt + 1'b1;
      end
   end

   // R3: the counter only moves on a sample tick
   p_tick_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_tick |=> $stable(tick_cnt));

endmodule

// File: rtl/am_err_accum.sv
module am_err_accum #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err_flag,
   input  logic             win_end,
   output logic [CNT_W-1:0] win_total,
   output logic [CNT_W-1:0] err_count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] acc;
   logic [CNT_W-1:0] acc_next;

   generate
      if (SATURATE) begin : g_sat
         assign acc_next = (err_flag && (acc != CNT_MAX)) ? acc + 1'b1 : acc;

         // R4: a full accumulator stays full until the window closes
         p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (acc == CNT_MAX) && !win_end |=> (acc == CNT_MAX));
      end else begin : g_wrap
         assign acc_next = acc + CNT_W'(err_flag);
      end
   endgenerate

   // R12: the flag on the closing cycle is part of the closing total
   assign win_total = acc_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc       <= '0;
         err_count <= '0;
      end else if (win_end) begin
         acc       <= '0;
         err_count <= acc_next;
      end else begin
         acc       <= acc_next;
      end
   end

   // R2: the latched byte moves only at a window end
   p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> $stable(err_count));

endmodule

// File: rtl/am_hysteresis.sv
module am_hysteresis #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_end,
   input  logic [CNT_W-1:0] win_total,
   input  logic [CNT_W-1:0] upper_lim,
   input  logic [CNT_W-1:0] lower_lim,
   input  logic             am_disable,
   output logic             engaged
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         engaged <= 1'b0;
      end else if (am_disable) begin
         engaged <= 1'b0;
      end else if (win_end) begin
         if (!engaged && (win_total >= upper_lim))     engaged <= 1'b1;
         else if (engaged && (win_total <= lower_lim)) engaged <= 1'b0;
      end
   end

   // R6: outside window ends, the state only moves when disabled
   p_am_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end && !am_disable |=> $stable(engaged));

   // R7: disabling forces the flag off on the next edge
   p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      am_disable |=> !engaged);

   // R5: a high window total engages
   p_engage_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !am_disable && win_end && !engaged && (win_total >= upper_lim) |=> engaged);

   // R6: a low window total releases
   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !am_disable && win_end && engaged && (win_total <= lower_lim) |=> !engaged);

endmodule

// File: rtl/am_out_select.sv
module am_out_select
   import automute_pkg::*;
(
   input  logic     vdsp,
   input  logic     mute_n,
   input  logic     mute_def,
   input  logic     rssf,
   input  logic     engaged,
   output src_sel_t src,
   output logic     zero_data
);
   logic mute_cond;

   // R10: an engaged automute acts as a pulled-low mute pin
   assign mute_cond = !mute_n || engaged;

   always_comb begin
      if (!vdsp)          src = SRC_FM;
      else if (mute_cond) src = (mute_def && rssf) ? SRC_FM : SRC_SILENT;
      else                src = SRC_DIGITAL;
   end

   assign zero_data = (src != SRC_DIGITAL);

endmodule

// File: rtl/automute_ctrl.sv
module automute_ctrl
   import automute_pkg::*;
#(
   parameter int CNT_W            = 8,
   parameter int TICKS_PER_WINDOW = 4096,
   parameter bit SATURATE         = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err_flag,
   input  logic             sample_tick,
   input  logic [CNT_W-1:0] upper_lim,
   input  logic [CNT_W-1:0] lower_lim,
   input  logic             am_disable,
   input  logic             mute_def,
   input  logic             rssf,
   input  logic             vdsp,
   input  logic             mute_n,
   output logic [CNT_W-1:0] err_count,
   output logic             am_flag,
   output logic [1:0]       src_sel,
   output logic             zero_data
);
   logic             win_end;
   logic [CNT_W-1:0] win_total;
   logic             engaged;
   src_sel_t         src;

   am_window_timer #(.TICKS_PER_WINDOW(TICKS_PER_WINDOW)) u_timer (
      .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .win_end(win_end)
   );

   am_err_accum #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_accum (
      .clk(clk), .rst_n(rst_n), .err_flag(err_flag), .win_end(win_end),
      .win_total(win_total), .err_count(err_count)
   );

   am_hysteresis #(.CNT_W(CNT_W)) u_hyst (
      .clk(clk), .rst_n(rst_n), .win_end(win_end), .win_total(win_total),
      .upper_lim(upper_lim), .lower_lim(lower_lim), .am_disable(am_disable),
      .engaged(engaged)
   );

   am_out_select u_sel (
      .vdsp(vdsp), .mute_n(mute_n), .mute_def(mute_def), .rssf(rssf),
      .engaged(engaged), .src(src), .zero_data(zero_data)
   );

   assign am_flag = engaged;
   assign src_sel = src;

   // R10: with valid digital sound, an engaged automute never passes digital
   p_am_not_digital_r10: assert property (@(posedge clk) disable iff (!rst_n)
      am_flag && vdsp |-> (src_sel != SRC_DIGITAL));

   // R8: invalid digital sound always reaches FM
   p_invalid_fm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !vdsp |-> (src_sel == SRC_FM) && zero_data);

endmodule

// File: tb/tb_automute_ctrl.sv
module tb_automute_ctrl;
   localparam int W = 8;
   localparam int T = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic err_flag = 1'b0, sample_tick = 1'b0;
   logic [W-1:0] upper_lim = 8'd6, lower_lim = 8'd2;
   logic am_disable = 1'b0, mute_def = 1'b0, rssf = 1'b0, vdsp = 1'b1, mute_n = 1'b1;
   logic [W-1:0] err_count;
   logic am_flag, zero_data;
   logic [1:0] src_sel;

   int n_checks = 0, n_fail = 0;
   bit exp_am = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   automute_ctrl #(.CNT_W(W), .TICKS_PER_WINDOW(T), .SATURATE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .err_flag(err_flag), .sample_tick(sample_tick),
      .upper_lim(upper_lim), .lower_lim(lower_lim), .am_disable(am_disable),
      .mute_def(mute_def), .rssf(rssf), .vdsp(vdsp), .mute_n(mute_n),
      .err_count(err_count), .am_flag(am_flag), .src_sel(src_sel), .zero_data(zero_data)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_src(bit v, bit m, bit md, bit r, bit am);
      if (!v) return 1;
      if (!m || am) return (md && r) ? 1 : 2;
      return 0;
   endfunction

   // n errors on consecutive cycles, then T ticks; optional error on the last tick
   task automatic run_window(input int nerr, input bit err_on_last);
      if (nerr > 0) begin
         @(negedge clk); err_flag = 1'b1;
         repeat (nerr) @(negedge clk);
         err_flag = 1'b0;
      end
      for (int t = 0; t < T; t++) begin
         @(negedge clk);
         sample_tick = 1'b1;
         err_flag = err_on_last && (t == T - 1);
         @(negedge clk);
         sample_tick = 1'b0;
         err_flag = 1'b0;
      end
   endtask

   function automatic int sat(int n);
      return (n > 255) ? 255 : n;
   endfunction

   task automatic window_and_check(input int nerr, input bit last, input string req);
      int total;
      total = sat(nerr + (last ? 1 : 0));
      run_window(nerr, last);
      if (am_disable) exp_am = 1'b0;
      else if (!exp_am && total >= upper_lim) exp_am = 1'b1;
      else if (exp_am && total <= lower_lim) exp_am = 1'b0;
      chk({req, " count"}, err_count, total);
      chk({req, " am"}, am_flag, exp_am);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 count", err_count, 0);
      chk("R1 am", am_flag, 0);
      chk("R1 src", src_sel, 0);
      chk("R1 zero", zero_data, 0);
      @(negedge clk); rst_n = 1'b1;

      // R3/R2: count hidden until the T-th tick
      @(negedge clk); err_flag = 1'b1;
      repeat (3) @(negedge clk);
      err_flag = 1'b0;
      for (int t = 0; t < T - 1; t++) begin
         @(negedge clk); sample_tick = 1'b1;
         @(negedge clk); sample_tick = 1'b0;
         chk("R2 hold before window end", err_count, 0);
      end
      @(negedge clk); sample_tick = 1'b1;
      @(negedge clk); sample_tick = 1'b0;
      chk("R3 count at T-th tick", err_count, 3);
      chk("R3 am below upper", am_flag, 0);

      // R5/R6 hysteresis sweep (upper 6, lower 2)
      window_and_check(5, 0, "R5 just below upper");
      window_and_check(6, 0, "R5 at upper");
      window_and_check(4, 0, "R6 between limits");
      window_and_check(3, 0, "R6 just above lower");
      window_and_check(2, 0, "R6 at lower");
      window_and_check(0, 0, "R6 zero");
      window_and_check(7, 0, "R5 above upper");
      window_and_check(1, 0, "R6 below lower");
      for (int n = 0; n < 10; n++) window_and_check(n, 0, "R5 R6 ramp");
      for (int n = 9; n >= 0; n--) window_and_check(n, 0, "R5 R6 descent");

      // R12: error on closing tick counts in closing window
      window_and_check(0, 0, "R12 setup");
      window_and_check(5, 1, "R12 closing flag");
      chk("R12 engaged by closing flag", am_flag, 1);
      window_and_check(0, 0, "R12 release");

      // R4: saturation
      window_and_check(300, 0, "R4 saturate");
      chk("R4 value", err_count, 255);
      window_and_check(255, 1, "R4 saturate edge");
      window_and_check(0, 0, "R4 release");

      // R7: disable clears and holds
      window_and_check(9, 0, "R7 engage first");
      @(negedge clk); am_disable = 1'b1;
      @(negedge clk);
      chk("R7 cleared", am_flag, 0);
      exp_am = 1'b0;
      window_and_check(20, 0, "R7 held off");
      chk("R7 counting continues", err_count, 20);
      @(negedge clk); am_disable = 1'b0;
      window_and_check(1, 0, "R7 re-enabled low");

      // R8 R9 R10 R11: exhaustive output sweep in both automute states
      for (int a = 0; a < 2; a++) begin
         if (a == 1) window_and_check(8, 0, "R10 engage");
         chk("R11 am flag state", am_flag, a);
         for (int c = 0; c < 16; c++) begin
            int e;
            @(negedge clk);
            vdsp = c[3]; mute_n = c[2]; mute_def = c[1]; rssf = c[0];
            #1;
            e = exp_src(c[3], c[2], c[1], c[0], a[0]);
            if (!c[3])                       chk("R8 invalid to FM", src_sel, e);
            else if (a == 1)                 chk("R10 automute as mute", src_sel, e);
            else                             chk("R9 pin mute", src_sel, e);
            chk("R11 zero strobe", zero_data, (e != 0) ? 1 : 0);
         end
      end
      @(negedge clk); vdsp = 1'b1; mute_n = 1'b1;

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule